// File: doc/BRIEF.md
# Power-Down Wake Controller

This block owns the sleep state of a small microcontroller. Software writes a one-cycle strobe to enter power-down. The block then drops the oscillator enable and gates the CPU and peripheral clocks. Nothing is clocked while the part sleeps, so the check for a valid wake request is purely combinational. A qualified request clears the sleep flag at once, which restarts the oscillator.

When the oscillator is running again, the block finds out which source woke the part and holds the CPU clock off until execution may safely resume. For an external interrupt line, that is the moment the line is released. For a key, it is a fixed settling count that runs while the key is still held. It then issues a one-cycle resume pulse together with a code naming the source, which the CPU uses to take the wake interrupt. A high level on the reset pin also clears the flag asynchronously.

Sleep and wake do not touch any register or memory content outside this block.

Top module: `pdw_ctrl`

## Requirements
- R1: After `rst` is released with no sleep request, `osc_en`, `cpu_clk_en` and `periph_clk_en` are all 1 and `resume` is 0.
- R2: A `pd_set` pulse sampled at a rising clock edge sets the sleep flag. From that edge on, `osc_en`, `cpu_clk_en` and `periph_clk_en` are all 0.
- R3: While sleeping, line `ext_irq[i]` going high wakes the part only if `ext_en[i]`, `ext_level_mode[i]` and `ext_top_prio[i]` are all 1. The wake sets `osc_en` and `periph_clk_en` to 1 at once, with no clock edge needed. `cpu_clk_en` stays 0 while the line is held.
- R4: After a wake on external line i, `resume` pulses at the third rising edge after the line falls, with `wake_src` equal to i (0 or 1). `cpu_clk_en` is 1 from that edge on.
- R5: An external line with any of its three qualifying bits at 0 does not end sleep.
- R6: Key bit k wakes the part only if `key_en[k]` is 1 and `key_in[k]` equals `key_active_high[k]` (1 means the key is active high, 0 means active low). A disabled key, or a key at the non-matching level, does not end sleep.
- R7: After a key wake, `resume` pulses with `wake_src` = 2 at the 1025th rising edge after the flag clears, even if the key is still held. `cpu_clk_en` stays 0 until that edge.
- R8: A high `rst` clears the sleep flag asynchronously, so `osc_en` and `periph_clk_en` become 1 before any clock edge. If the reset ended a sleep, `resume` pulses with `wake_src` = 3 at the first rising edge after `rst` falls.
- R9: When several qualified sources are active together, external line 0 wins over line 1, and line 1 wins over the keys.
- R10: While any qualified wake request is active, `pd_set` has no effect and `osc_en` stays 1.
- R11: `resume` is high for exactly one cycle per wake. `wake_src` holds its value between pulses.
- R12: The settling count restarts at every entry into sleep, so each key wake waits the full 1025 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (stopped in hardware while asleep) |
| rst | input | 1 | Reset pin, active high; clears the sleep flag asynchronously |
| pd_set | input | 1 | Write strobe that requests power-down |
| ext_irq | input | N_EXT | External interrupt lines, active high, asynchronous |
| ext_en | input | N_EXT | Per-line interrupt enable |
| ext_level_mode | input | N_EXT | 1 = line configured as level-sensitive |
| ext_top_prio | input | N_EXT | 1 = line assigned the highest priority |
| key_in | input | N_KEY | Keyboard lines, asynchronous |
| key_en | input | N_KEY | Per-key wake enable |
| key_active_high | input | N_KEY | Per-key active level (1 high, 0 low) |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| resume | output | 1 | One-cycle pulse: take the wake interrupt |
| wake_src | output | 2 | Source of the last wake: 0 line 0, 1 line 1, 2 key, 3 reset |

## Verification
Wakes come from line 1 alone, line 0 alone, both lines raised together, and line 1 raised together with a held key. These patterns separate the release-timed path from the count-timed path and expose the priority order. Several stimuli are applied during sleep that must not wake the part: each qualifying bit of a line cleared in turn, a key at the wrong level, and a matching key that is disabled. Any of them ending sleep points to a qualification fault rather than a timing fault. Two key wakes in a row, with the key held past the resume point, show that the count restarts at each sleep and does not depend on the key being released. A reset during sleep is checked for the clock enables coming back before any edge.

// File: rtl/pdw_pkg.sv
package pdw_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_SLEEP,
    ST_START,
    ST_RELEASE,
    ST_SETTLE,
    ST_RSTEXIT
  } pdw_state_t;

  typedef logic [1:0] wake_code_t;

  localparam wake_code_t CODE_KEY = 2'd2;
  localparam wake_code_t CODE_RST = 2'd3;

endpackage

// File: rtl/pdw_sync.sv
module pdw_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pdw_wake_qual.sv
module pdw_wake_qual #(
  parameter int N_EXT = 2,
  parameter int N_KEY = 4
) (
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_EXT-1:0] ext_level_mode,
  input  logic [N_EXT-1:0] ext_top_prio,
  input  logic [N_KEY-1:0] key_in,
  input  logic [N_KEY-1:0] key_en,
  input  logic [N_KEY-1:0] key_active_high,
  output logic [N_EXT-1:0] ext_hit,
  output logic             key_hit
);

  logic [N_KEY-1:0] key_match;

  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    assign ext_hit[i] = ext_irq[i] & ext_en[i] & ext_level_mode[i] & ext_top_prio[i];
  end

  for (genvar k = 0; k < N_KEY; k++) begin : g_key
    assign key_match[k] = key_en[k] & ~(key_in[k] ^ key_active_high[k]);
  end

  assign key_hit = |key_match;

endmodule

// File: rtl/pdw_settle_cnt.sv
module pdw_settle_cnt #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic clear,
  input  logic step,
  output logic done
);

  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clear)     cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);

endmodule

// File: rtl/pdw_ctrl.sv
module pdw_ctrl
  import pdw_pkg::*;
#(
  parameter int N_EXT        = 2,
  parameter int N_KEY        = 4,
  parameter int SETTLE_COUNT = 1024,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pd_set,
  input  logic [N_EXT-1:0] ext_irq,
  input  logic [N_EXT-1:0] ext_en,
  input  logic [N_EXT-1:0] ext_level_mode,
  input  logic [N_EXT-1:0] ext_top_prio,
  input  logic [N_KEY-1:0] key_in,
  input  logic [N_KEY-1:0] key_en,
  input  logic [N_KEY-1:0] key_active_high,
  output logic             osc_en,
  output logic             cpu_clk_en,
  output logic             periph_clk_en,
  output logic             resume,
  output logic [1:0]       wake_src
);

  localparam int EW = (N_EXT > 1) ? $clog2(N_EXT) : 1;
  localparam int SW = N_EXT + N_KEY;

  logic [N_EXT-1:0] ext_hit_raw, ext_hit_s;
  logic             key_hit_raw, key_hit_s;
  logic [SW-1:0]    sync_q;
  logic             flag_clr, pd_flag;
  logic [EW-1:0]    first_ext, sel_ext;
  logic             settle_done, cpu_hold;
  pdw_state_t       state;

  // Combinational wake qualification: usable while no clock runs
  pdw_wake_qual #(.N_EXT(N_EXT), .N_KEY(N_KEY)) u_qual_raw (
    .ext_irq(ext_irq), .ext_en(ext_en), .ext_level_mode(ext_level_mode),
    .ext_top_prio(ext_top_prio), .key_in(key_in), .key_en(key_en),
    .key_active_high(key_active_high), .ext_hit(ext_hit_raw), .key_hit(key_hit_raw)
  );

  pdw_sync #(.W(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({key_in, ext_irq}), .q(sync_q)
  );

  // Same qualification on synchronized lines for the resume decisions
  pdw_wake_qual #(.N_EXT(N_EXT), .N_KEY(N_KEY)) u_qual_sync (
    .ext_irq(sync_q[N_EXT-1:0]), .ext_en(ext_en), .ext_level_mode(ext_level_mode),
    .ext_top_prio(ext_top_prio), .key_in(sync_q[SW-1:N_EXT]), .key_en(key_en),
    .key_active_high(key_active_high), .ext_hit(ext_hit_s), .key_hit(key_hit_s)
  );

  assign flag_clr = rst | (|ext_hit_raw) | key_hit_raw;

  always_ff @(posedge clk or posedge flag_clr) begin
    if (flag_clr)    pd_flag <= 1'b0;
    else if (pd_set) pd_flag <= 1'b1;
  end

  // Lowest-numbered active line wins
  always_comb begin
    first_ext = '0;
    for (int i = N_EXT - 1; i >= 0; i--) begin
      if (ext_hit_s[i]) first_ext = EW'(i);
    end
  end

  pdw_settle_cnt #(.LIMIT(SETTLE_COUNT)) u_settle (
    .clk(clk),
    .clear(rst | (state == ST_SLEEP)),
    .step((state == ST_START) | (state == ST_SETTLE)),
    .done(settle_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ((state == ST_SLEEP) || (state == ST_RSTEXIT)) ? ST_RSTEXIT : ST_RUN;
      resume   <= 1'b0;
      wake_src <= '0;
      sel_ext  <= '0;
    end else begin
      resume <= 1'b0;
      case (state)
        ST_RUN:   if (pd_flag) state <= ST_SLEEP;
        ST_SLEEP: if (!pd_flag) state <= ST_START;
        ST_START: begin
          if (|ext_hit_s) begin
            sel_ext <= first_ext;
            state   <= ST_RELEASE;
          end else if (key_hit_s) begin
            state <= ST_SETTLE;
          end
        end
        ST_RELEASE: begin
          if (!ext_hit_s[sel_ext]) begin
            resume   <= 1'b1;
            wake_src <= 2'(sel_ext);
            state    <= ST_RUN;
          end
        end
        ST_SETTLE: begin
          if (settle_done) begin
            resume   <= 1'b1;
            wake_src <= CODE_KEY;
            state    <= ST_RUN;
          end
        end
        ST_RSTEXIT: begin
          resume   <= 1'b1;
          wake_src <= CODE_RST;
          state    <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign cpu_hold      = (state == ST_SLEEP) || (state == ST_START) ||
                         (state == ST_RELEASE) || (state == ST_SETTLE);
  assign osc_en        = ~pd_flag;
  assign periph_clk_en = ~pd_flag;
  assign cpu_clk_en    = ~pd_flag & ~cpu_hold;

endmodule

// File: rtl/pdw_ctrl_chk.sv
module pdw_ctrl_chk
  import pdw_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       osc_en,
  input logic       periph_clk_en,
  input logic       cpu_clk_en,
  input logic       resume,
  input logic [1:0] wake_src
);

  // R8
  rst_wakes_osc_chk: assert property (@(posedge clk)
    (rst && $past(rst)) |-> (osc_en && periph_clk_en));

  // R11
  resume_single_chk: assert property (@(posedge clk) disable iff (rst)
    resume |=> !resume);

  // R11
  src_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !resume |=> (resume || $stable(wake_src)));

  // R3
  wake_holds_cpu_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(osc_en) |-> !cpu_clk_en);

  // R7
  resume_after_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (resume && (wake_src != CODE_RST)) |-> !$past(cpu_clk_en));

endmodule

bind pdw_ctrl pdw_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .osc_en(osc_en), .periph_clk_en(periph_clk_en),
  .cpu_clk_en(cpu_clk_en), .resume(resume), .wake_src(wake_src)
);

// File: tb/pdw_ctrl_test.sv
module pdw_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int N_EXT  = 2;
  localparam int N_KEY  = 4;
  localparam int SETTLE = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pd_set = 1'b0;
  logic [N_EXT-1:0] ext_irq = '0, ext_en = '1, ext_level_mode = '1, ext_top_prio = '1;
  logic [N_KEY-1:0] key_in = '1, key_en = '0, key_active_high = '0;
  logic osc_en, cpu_clk_en, periph_clk_en, resume;
  logic [1:0] wake_src;

  typedef struct { int src; int at; } exp_t;
  exp_t exp_q[$];

  int cyc = 0;
  int vectors = 0;
  int miscompares = 0;
  bit prev_resume = 1'b0;
  bit finished = 1'b0;

  pdw_ctrl #(.N_EXT(N_EXT), .N_KEY(N_KEY), .SETTLE_COUNT(SETTLE)) uut (
    .clk(clk), .rst(rst), .pd_set(pd_set), .ext_irq(ext_irq), .ext_en(ext_en),
    .ext_level_mode(ext_level_mode), .ext_top_prio(ext_top_prio), .key_in(key_in),
    .key_en(key_en), .key_active_high(key_active_high), .osc_en(osc_en),
    .cpu_clk_en(cpu_clk_en), .periph_clk_en(periph_clk_en), .resume(resume),
    .wake_src(wake_src)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push_exp(input int src, input int at);
    exp_t e;
    e.src = src;
    e.at  = at;
    exp_q.push_back(e);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_pd();
    pd_set = 1'b1;
    tick(1);
    pd_set = 1'b0;
    tick(3);
  endtask

  function automatic string req_of(input int src);
    if (src == 2) return "R7";
    if (src == 3) return "R8";
    return "R4";
  endfunction

  // Monitor: pops expected wakes as resume pulses appear
  always @(negedge clk) begin
    if (resume) begin
      if (prev_resume) check(1'b0, "R11", "resume longer than one cycle", 2, 1);
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected resume, wake_src", int'(wake_src), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(int'(wake_src) == e.src, req_of(e.src), "wake_src", int'(wake_src), e.src);
        check(cyc == e.at, req_of(e.src), "resume cycle", cyc, e.at);
      end
    end
    prev_resume = resume;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    check(osc_en == 1'b1, "R1", "osc_en", osc_en, 1);
    check(cpu_clk_en == 1'b1, "R1", "cpu_clk_en", cpu_clk_en, 1);
    check(periph_clk_en == 1'b1, "R1", "periph_clk_en", periph_clk_en, 1);
    check(resume == 1'b0, "R1", "resume", resume, 0);

    // R2 enter sleep
    enter_pd();
    check(osc_en == 1'b0, "R2", "osc_en", osc_en, 0);
    check(cpu_clk_en == 1'b0, "R2", "cpu_clk_en", cpu_clk_en, 0);
    check(periph_clk_en == 1'b0, "R2", "periph_clk_en", periph_clk_en, 0);

    // R5 each qualifying bit cleared in turn
    ext_en = 2'b10; tick(1);
    ext_irq[0] = 1'b1; tick(4);
    check(osc_en == 1'b0, "R5", "disabled line woke", osc_en, 0);
    ext_irq[0] = 1'b0; tick(1);
    ext_en = 2'b11; ext_level_mode = 2'b01; tick(1);
    ext_irq[1] = 1'b1; tick(4);
    check(osc_en == 1'b0, "R5", "edge-mode line woke", osc_en, 0);
    ext_irq[1] = 1'b0; tick(1);
    ext_level_mode = 2'b11; ext_top_prio = 2'b10; tick(1);
    ext_irq[0] = 1'b1; tick(4);
    check(osc_en == 1'b0, "R5", "low-priority line woke", osc_en, 0);
    ext_irq[0] = 1'b0; tick(1);
    ext_top_prio = 2'b11; tick(1);

    // R6 wrong level, then disabled matching key
    key_active_high = 4'b0001; key_in = 4'b1110; tick(1);
    key_en = 4'b0001; tick(4);
    check(osc_en == 1'b0, "R6", "wrong-level key woke", osc_en, 0);
    key_en = 4'b0000; tick(1);
    key_in = 4'b1111; tick(4);
    check(osc_en == 1'b0, "R6", "disabled key woke", osc_en, 0);
    key_in = 4'b1110; tick(1);
    key_active_high = 4'b0000; key_in = 4'b1111; tick(2);

    // R3/R4 wake on line 1
    ext_irq[1] = 1'b1;
    #1;
    check(osc_en == 1'b1, "R3", "osc_en before edge", osc_en, 1);
    check(periph_clk_en == 1'b1, "R3", "periph_clk_en before edge", periph_clk_en, 1);
    check(cpu_clk_en == 1'b0, "R3", "cpu_clk_en at wake", cpu_clk_en, 0);
    tick(6);
    check(cpu_clk_en == 1'b0, "R3", "cpu_clk_en while line held", cpu_clk_en, 0);
    ext_irq[1] = 1'b0;
    push_exp(1, cyc + 3);
    tick(5);
    check(cpu_clk_en == 1'b1, "R4", "cpu_clk_en after release", cpu_clk_en, 1);

    // R10 sleep request ignored while a wake request is active
    ext_irq[0] = 1'b1; tick(3);
    pd_set = 1'b1; tick(1);
    pd_set = 1'b0; tick(2);
    check(osc_en == 1'b1, "R10", "osc_en after blocked pd_set", osc_en, 1);
    check(cpu_clk_en == 1'b1, "R10", "cpu_clk_en after blocked pd_set", cpu_clk_en, 1);
    ext_irq[0] = 1'b0; tick(4);

    // R4 wake on line 0
    enter_pd();
    ext_irq[0] = 1'b1; tick(6);
    ext_irq[0] = 1'b0;
    push_exp(0, cyc + 3);
    tick(6);

    // R9 both lines together: line 0 wins
    enter_pd();
    ext_irq = 2'b11; tick(6);
    ext_irq = 2'b00;
    push_exp(0, cyc + 3);
    tick(6);

    // R9 line 1 together with a held key: line 1 wins
    key_en = 4'b0100; tick(2);
    enter_pd();
    ext_irq[1] = 1'b1; key_in[2] = 1'b0; tick(6);
    ext_irq[1] = 1'b0;
    push_exp(1, cyc + 3);
    tick(6);
    key_in = 4'b1111; tick(4);

    // R7 key wake, key held past the resume point
    enter_pd();
    key_in[2] = 1'b0;
    push_exp(2, cyc + SETTLE + 1);
    tick(SETTLE);
    check(cpu_clk_en == 1'b0, "R7", "cpu_clk_en one edge before count", cpu_clk_en, 0);
    tick(1);
    check(cpu_clk_en == 1'b1, "R7", "cpu_clk_en with key held", cpu_clk_en, 1);
    tick(10);
    check(wake_src == 2'd2, "R11", "wake_src held", int'(wake_src), 2);
    key_in = 4'b1111; tick(4);

    // R12 second key wake gets the full count
    enter_pd();
    key_in[2] = 1'b0;
    push_exp(2, cyc + SETTLE + 1);
    tick(SETTLE + 6);
    key_in = 4'b1111; tick(4);

    // R8 reset during sleep
    enter_pd();
    tick(3);
    rst = 1'b1;
    #1;
    check(osc_en == 1'b1, "R8", "osc_en before edge", osc_en, 1);
    check(periph_clk_en == 1'b1, "R8", "periph_clk_en before edge", periph_clk_en, 1);
    tick(3);
    rst = 1'b0;
    push_exp(3, cyc + 1);
    tick(6);

    check(exp_q.size() == 0, "R11", "expected resumes not seen", exp_q.size(), 0);
    finish_run();
  end

endmodule